// File: doc/BRIEF.md
# Asynchronous Bus Slave Address Decoder

This block sits on the slave side of a backplane bus that carries no clock. It synchronizes the address strobe and the two data strobes into the local clock domain. When the address strobe falls it latches the address-modifier code, the address and the direction. It then checks the address-modifier code against a fixed table of accepted codes. It also compares the upper address bits of the selected address space with a base value set on switches.

On a hit, each data strobe (one beat) produces a single one-cycle strobe to the local logic, together with a byte offset. The bus acknowledge is asserted only after read data is registered on the output. It stays asserted until both data strobes return high.

Block transfers keep one latched address for the whole address-strobe period. The offset moves forward after every beat. A small register file of 32-bit words sits behind the decoder, so that writes and read-backs can be seen at the bus.

A strobe that carries an unknown code or a foreign base gets no response at all. The bus master then detects the missing answer through its own timeout.

Top module: `vme_slave_decode`

## Requirements
- R1: After reset, `dtack_n` is high, `data_oe` is low, and `loc_wr` and `loc_rd` are low.
- R2: These address-modifier codes are accepted:
  - 0x29: 16-bit space, single cycle.
  - 0x39: 24-bit space, single cycle.
  - 0x3B: 24-bit space, block transfer.
  - 0x09: 32-bit space, single cycle.
  - 0x0B: 32-bit space, block transfer.
  - 0x08: 32-bit space, 64-bit multiplexed block transfer.

  With a matching base, each of these codes is answered by `dtack_n` going low.
- R3: Any other code gets no acknowledge and no local strobe, and the register file is left unchanged. This includes 0x2F, the configuration space, which this block does not claim.
- R4: The base match depends on the address space:
  - 32-bit space: `addr[31:16]` must equal `base_sw[15:0]`, and the offset is `addr[15:0]`.
  - 24-bit space: `addr[23:16]` must equal `base_sw[7:0]`, and the offset is `addr[15:0]`.
  - 16-bit space: `addr[15:8]` must equal `base_sw[7:0]`, and the offset is `addr[7:0]`.

  A mismatch gets no response.
- R5: A write beat (`write_n` low) stores `data_in` in the word selected by offset bits [3:2]. A read beat places that word on `data_out` with `data_oe` high while `dtack_n` is low.
- R6: Once low, `dtack_n` stays low while either data strobe is low. It returns high after both data strobes are high.
- R7: In block-transfer codes the offset rises by 4 after each beat, and by 8 after each beat for code 0x08. Single-cycle codes keep the latched offset.
- R8: `dtack_n` falls no sooner than three clock edges after the data strobe falls. Exactly one `loc_wr` or `loc_rd` pulse precedes each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Data strobe 0, active low |
| ds1_n | input | 1 | Data strobe 1, active low |
| write_n | input | 1 | Direction, low means write |
| am | input | 6 | Address-modifier code |
| addr | input | 32 | Bus address |
| data_in | input | 32 | Write data from the bus |
| base_sw | input | 16 | Base address switches |
| data_out | output | 32 | Read data toward the bus |
| data_oe | output | 1 | Drive enable for read data |
| dtack_n | output | 1 | Acknowledge, active low |
| loc_off | output | 16 | Current byte offset to local logic |
| loc_wr | output | 1 | One-cycle local write strobe |
| loc_rd | output | 1 | One-cycle local read strobe |

## Verification
Each fault shows up at the ports within a single beat:
- A wrong decode entry or base comparison shows up as an acknowledge that is missing or unexpected. It can also show up as a register that changed when it should not have, which the next read-back exposes.
- A corrupted offset counter shows up as block-transfer data landing in the wrong word, and as the wrong value on `loc_off` at the following beat's strobe.
- A handshake state that leaves too early or too late shows up as `dtack_n` rising while a strobe is still held low, or as an acknowledge that arrives before the synchronizer delay has passed.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_A16  = 2'd1,
        SP_A24  = 2'd2,
        SP_A32  = 2'd3
    } space_e;

    typedef struct packed {
        space_e space;
        logic   blk;
        logic   wide;
    } am_info_t;

    typedef struct packed {
        logic        hit;
        logic        blk;
        logic        wide;
        logic [15:0] off;
    } decode_t;

    localparam logic [15:0] STEP_BLT  = 16'd4;
    localparam logic [15:0] STEP_WIDE = 16'd8;

    function automatic am_info_t am_lookup(input logic [5:0] code);
        am_info_t r;
        r = '{space: SP_NONE, blk: 1'b0, wide: 1'b0};
        case (code)
            6'h29: r.space = SP_A16;
            6'h39: r.space = SP_A24;
            6'h3B: begin r.space = SP_A24; r.blk = 1'b1; end
            6'h09: r.space = SP_A32;
            6'h0B: begin r.space = SP_A32; r.blk = 1'b1; end
            6'h08: begin r.space = SP_A32; r.blk = 1'b1; r.wide = 1'b1; end
            default: r.space = SP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vsd_sync.sv
module vsd_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/vsd_am_decode.sv
module vsd_am_decode
    import vsd_pkg::*;
(
    input  logic [5:0]  am,
    input  logic [31:0] addr,
    input  logic [15:0] base_sw,
    output decode_t     dec
);
    am_info_t info;

    always_comb begin
        info     = am_lookup(am);
        dec.blk  = info.blk;
        dec.wide = info.wide;
        dec.off  = addr[15:0];
        dec.hit  = 1'b0;
        case (info.space)
            SP_A32: dec.hit = (addr[31:16] == base_sw);
            SP_A24: dec.hit = (addr[23:16] == base_sw[7:0]);
            SP_A16: begin
                dec.hit = (addr[15:8] == base_sw[7:0]);
                dec.off = {8'h00, addr[7:0]};
            end
            default: dec.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vsd_regfile.sv
module vsd_regfile #(
    parameter int NREGS = 4,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NREGS];

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)                        mem[i] <= '0;
                else if (we && idx == IW'(i))   mem[i] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[idx];
endmodule

// File: rtl/vme_slave_decode.sv
module vme_slave_decode
    import vsd_pkg::*;
#(
    parameter int NREGS = 4,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        as_n,
    input  logic        ds0_n,
    input  logic        ds1_n,
    input  logic        write_n,
    input  logic [5:0]  am,
    input  logic [31:0] addr,
    input  logic [31:0] data_in,
    input  logic [15:0] base_sw,
    output logic [31:0] data_out,
    output logic        data_oe,
    output logic        dtack_n,
    output logic [15:0] loc_off,
    output logic        loc_wr,
    output logic        loc_rd
);
    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACCESS, ST_ACK} state_e;

    state_e      state;
    logic [2:0]  strb_s;
    logic        as_act, ds_act, ds_idle;
    decode_t     dec, cyc;
    logic        wr_lat;
    logic [31:0] rdata, rdata_q;

    vsd_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({as_n, ds1_n, ds0_n}),
        .q   (strb_s)
    );

    assign as_act  = !strb_s[2];
    assign ds_act  = !strb_s[0] || !strb_s[1];
    assign ds_idle = strb_s[0] && strb_s[1];

    vsd_am_decode u_dec (
        .am      (am),
        .addr    (addr),
        .base_sw (base_sw),
        .dec     (dec)
    );

    vsd_regfile #(.NREGS(NREGS), .DW(32)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (loc_wr),
        .idx   (cyc.off[IW+1:2]),
        .wdata (data_in),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cyc     <= '0;
            wr_lat  <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (as_act) begin
                    cyc    <= dec;
                    wr_lat <= !write_n;
                    state  <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (!as_act)                 state <= ST_IDLE;
                    else if (ds_act && cyc.hit)  state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    rdata_q <= rdata;
                    state   <= ST_ACK;
                end
                ST_ACK: if (ds_idle) begin
                    if (cyc.blk)
                        cyc.off <= cyc.off + (cyc.wide ? STEP_WIDE : STEP_BLT);
                    state <= ST_ADDR;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign loc_wr   = (state == ST_ACCESS) && wr_lat;
    assign loc_rd   = (state == ST_ACCESS) && !wr_lat;
    assign loc_off  = cyc.off;
    assign dtack_n  = !(state == ST_ACK);
    assign data_oe  = (state == ST_ACK) && !wr_lat;
    assign data_out = rdata_q;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
    input logic clk,
    input logic rst,
    input logic ds0_n,
    input logic ds1_n,
    input logic dtack_n,
    input logic data_oe,
    input logic loc_wr,
    input logic loc_rd
);
    AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !dtack_n); // R5

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && (!ds0_n || !ds1_n) && $past(!ds0_n || !ds1_n)) |=> !dtack_n); // R6

    AST_RELEASE_AFTER_DS: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack_n) |-> $past(ds0_n && ds1_n)); // R6

    AST_ACK_AFTER_DS: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> $past(!ds0_n || !ds1_n)); // R8

    AST_STROBE_THEN_ACK: assert property (@(posedge clk) disable iff (rst)
        (loc_wr || loc_rd) |=> $fell(dtack_n)); // R8

    AST_NO_STROBE_DURING_ACK: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> !(loc_wr || loc_rd)); // R8
endmodule

bind vme_slave_decode vsd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .ds0_n   (ds0_n),
    .ds1_n   (ds1_n),
    .dtack_n (dtack_n),
    .data_oe (data_oe),
    .loc_wr  (loc_wr),
    .loc_rd  (loc_rd)
);

// File: tb/tb_vme_slave_decode.sv
module tb_vme_slave_decode;
    logic        clk = 0;
    logic        rst = 1;
    logic        as_n = 1, ds0_n = 1, ds1_n = 1, write_n = 1;
    logic [5:0]  am = '0;
    logic [31:0] addr = '0, data_in = '0;
    logic [15:0] base_sw = 16'hC248;
    logic [31:0] data_out;
    logic        data_oe, dtack_n, loc_wr, loc_rd;
    logic [15:0] loc_off;

    int n_chk = 0, n_bad = 0, n_strobe = 0;
    logic [15:0] last_off = '0;
    bit done = 0;

    always #10 clk = ~clk;

    vme_slave_decode dut (
        .clk(clk), .rst(rst), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
        .write_n(write_n), .am(am), .addr(addr), .data_in(data_in),
        .base_sw(base_sw), .data_out(data_out), .data_oe(data_oe),
        .dtack_n(dtack_n), .loc_off(loc_off), .loc_wr(loc_wr), .loc_rd(loc_rd)
    );

    always @(negedge clk) if (loc_wr || loc_rd) begin
        last_off <= loc_off;
        n_strobe <= n_strobe + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_cycle(input logic [5:0] code, input logic [31:0] a, input bit wr);
        @(negedge clk);
        am = code; addr = a; write_n = !wr;
        @(negedge clk);
        as_n = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_cycle();
        @(negedge clk);
        as_n = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic beat(input logic [31:0] wd, input int hold,
                        output bit acked, output logic [31:0] rd, output int lat);
        acked = 0; rd = '0; lat = 0;
        data_in = wd;
        ds0_n = 0; ds1_n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            lat++;
            if (!dtack_n) begin acked = 1; break; end
        end
        if (acked) begin
            rd = data_out;
            if (!write_n) check(!data_oe, "R5", data_oe, 0);
            else          check(data_oe, "R5", data_oe, 1);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(!dtack_n, "R6", dtack_n, 0);
            end
        end
        ds0_n = 1; ds1_n = 1;
        repeat (5) @(negedge clk);
        if (acked) check(dtack_n, "R6", dtack_n, 1);
    endtask

    task automatic single(input logic [5:0] code, input logic [31:0] a, input bit wr,
                          input logic [31:0] wd, output bit acked, output logic [31:0] rd);
        int lat;
        open_cycle(code, a, wr);
        beat(wd, 0, acked, rd, lat);
        close_cycle();
    endtask

    task automatic read_word(input int idx, output logic [31:0] rd);
        bit ak;
        single(6'h09, 32'hC2480000 | (idx * 4), 0, '0, ak, rd);
        check(ak, "R5", ak, 1);
    endtask

    task automatic t_reset();
        check(dtack_n === 1'b1, "R1", dtack_n, 1);
        check(data_oe === 1'b0, "R1", data_oe, 0);
        check(loc_wr === 1'b0 && loc_rd === 1'b0, "R1", {loc_wr, loc_rd}, 0);
    endtask

    task automatic t_codes();
        bit ak; logic [31:0] rd; int lat;
        single(6'h09, 32'hC2480004, 1, 32'h1111_0001, ak, rd);
        check(ak, "R2 0x09", ak, 1);
        single(6'h39, 32'h00480008, 1, 32'h2222_0002, ak, rd);
        check(ak, "R2 0x39", ak, 1);
        single(6'h29, 32'h0000480C, 1, 32'h3333_0003, ak, rd);
        check(ak, "R2 0x29", ak, 1);
        single(6'h29, 32'h00004804, 0, '0, ak, rd);
        check(ak && rd == 32'h1111_0001, "R5 A16 read", rd, 32'h1111_0001);
        single(6'h39, 32'h0048000C, 0, '0, ak, rd);
        check(ak && rd == 32'h3333_0003, "R5 A24 read", rd, 32'h3333_0003);
        open_cycle(6'h0B, 32'hC2480008, 0);
        beat('0, 6, ak, rd, lat);
        check(ak && rd == 32'h2222_0002, "R2 0x0B", rd, 32'h2222_0002);
        check(lat >= 3 && lat <= 6, "R8 latency", lat, 4);
        close_cycle();
    endtask

    task automatic t_silent();
        bit ak; logic [31:0] rd; int s0;
        s0 = n_strobe;
        single(6'h2F, 32'hC2480000, 1, 32'hDEAD_0001, ak, rd);
        check(!ak, "R3 0x2F", ak, 0);
        single(6'h0D, 32'hC2480000, 1, 32'hDEAD_0002, ak, rd);
        check(!ak, "R3 0x0D", ak, 0);
        single(6'h09, 32'hC2490000, 1, 32'hDEAD_0003, ak, rd);
        check(!ak, "R4 A32 base", ak, 0);
        single(6'h39, 32'h00490000, 1, 32'hDEAD_0004, ak, rd);
        check(!ak, "R4 A24 base", ak, 0);
        single(6'h29, 32'h00004900, 1, 32'hDEAD_0005, ak, rd);
        check(!ak, "R4 A16 base", ak, 0);
        check(n_strobe == s0, "R3 strobes", n_strobe - s0, 0);
        read_word(0, rd);
        check(rd == 32'h0, "R3 word0 kept", rd, 0);
    endtask

    task automatic t_block();
        bit ak; logic [31:0] rd; int lat, s0;
        open_cycle(6'h0B, 32'hC2480000, 1);
        for (int b = 0; b < 4; b++) begin
            s0 = n_strobe;
            beat(32'hB000_0000 + b, 0, ak, rd, lat);
            check(ak, "R2 blt beat", ak, 1);
            check(n_strobe == s0 + 1, "R8 one strobe", n_strobe - s0, 1);
            check(last_off == 16'(b * 4), "R7 blt offset", last_off, b * 4);
        end
        close_cycle();
        for (int b = 0; b < 4; b++) begin
            read_word(b, rd);
            check(rd == 32'hB000_0000 + b, "R7 blt data", rd, 32'hB000_0000 + b);
        end
        open_cycle(6'h08, 32'hC2480000, 1);
        for (int b = 0; b < 2; b++) begin
            beat(32'hC000_0000 + b, 0, ak, rd, lat);
            check(ak, "R2 0x08", ak, 1);
            check(last_off == 16'(b * 8), "R7 mblt offset", last_off, b * 8);
        end
        close_cycle();
        read_word(2, rd);
        check(rd == 32'hC000_0001, "R7 mblt data", rd, 32'hC000_0001);
        read_word(1, rd);
        check(rd == 32'hB000_0001, "R7 mblt skip", rd, 32'hB000_0001);
        open_cycle(6'h3B, 32'h00480004, 0);
        beat('0, 0, ak, rd, lat);
        check(ak && rd == 32'hB000_0001, "R2 0x3B", rd, 32'hB000_0001);
        beat('0, 0, ak, rd, lat);
        check(ak && rd == 32'hC000_0001, "R7 a24 blk", rd, 32'hC000_0001);
        close_cycle();
        open_cycle(6'h09, 32'hC2480004, 0);
        beat('0, 0, ak, rd, lat);
        beat('0, 0, ak, rd, lat);
        check(last_off == 16'h0004, "R7 single holds", last_off, 4);
        close_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_silent();
        t_block();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule